// File: doc/BRIEF.md
# Receiver Margin Scan Controller

This block is the digital sequencer behind on-die receiver margining. It drives two codes into the analog receive path: a voltage-offset code for the slicer and a phase code for the sampling interpolator. It steps those codes across a rectangular grid. At each grid point it waits for the analog path to settle and then counts one bit per clock over a window of 2^K samples. Each count is delivered through a single-cycle result write. The analog slicer, the interpolator and the pattern source sit outside the block.

One counting engine serves three scan modes. In noise mode the receiver sees a fixed DC level. The block sweeps only the offset code, along one phase row, and counts received ones. This gives the cumulative distribution of the input-referred noise. A second write port carries the first difference of adjacent counts, which is the density. In waveform mode the input is a repeating signal, and the block counts ones over the full offset-by-phase grid. This reconstructs the signal in equivalent time. In eye mode the block counts mismatches between the sampled bit and the expected bit at every grid point, and marks each point pass or fail against a threshold.

Top module: `rx_margin_scan`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `res_we` and `pdf_we` are 0, and both code outputs are 0.
- R2: When `start` is seen while idle, the block latches the mode, window exponent, settle length, error limit and code ranges. In noise mode (`scan_mode`=0) it visits offsets `off_first`..`off_last` in ascending order on phase `ph_first` only, and writes one result per offset.
- R3: In waveform mode (`scan_mode`=1) and eye mode (`scan_mode`=2 or 3), the phase is the outer loop from `ph_first` to `ph_last` and the offset is the inner loop from `off_first` to `off_last`. `res_addr` is {phase code, offset code}, with the offset in the low OFF_W bits.
- R4: Each point takes `settle_len` settle cycles after its codes are applied, then exactly 2^K counted samples, then one write cycle. The codes do not change while samples are counted. `done` rises N*(settle_len+2^K+1) cycles after the start edge, where N is the number of points.
- R5: In noise and waveform modes the count is the number of counted cycles with `sample_bit`=1.
- R6: In eye mode the count is the number of counted cycles with `sample_bit` different from `expect_bit`. For every point, `res_pass` is 1 exactly when the count is at most `err_limit`.
- R7: The count saturates at 2^CNT_W-1 and never wraps.
- R8: The requested `win_log2` is clamped into [MIN_WIN_LOG2, MAX_WIN_LOG2] before use.
- R9: In noise mode, every write after the first offset of the row also pulses `pdf_we`, with `pdf_val` = previous count minus current count as a signed value. `pdf_we` is never raised in the other modes or at the first offset.
- R10: `done` is a one-cycle pulse in the cycle after the last write, and `busy` falls with it. A `start` seen while busy is ignored and does not alter the running scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan when idle |
| scan_mode | input | 2 | 0 noise, 1 waveform, 2/3 eye |
| win_log2 | input | WINK_W | Requested window exponent K |
| settle_len | input | SETTLE_W | Settle cycles after each code change |
| err_limit | input | CNT_W | Pass threshold for a point |
| off_first | input | OFF_W | First offset code |
| off_last | input | OFF_W | Last offset code |
| ph_first | input | PH_W | First phase code |
| ph_last | input | PH_W | Last phase code |
| sample_bit | input | 1 | Slicer decision |
| expect_bit | input | 1 | Expected data bit |
| off_code | output | OFF_W | Offset code to the slicer |
| ph_code | output | PH_W | Phase code to the interpolator |
| res_we | output | 1 | Result write strobe |
| res_addr | output | OFF_W+PH_W | {phase, offset} of the result |
| res_count | output | CNT_W | Ones or error count |
| res_pass | output | 1 | Count at or below limit |
| pdf_we | output | 1 | Density write strobe (noise mode) |
| pdf_val | output | CNT_W+1 | Signed first difference of counts |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The bench builds the block with 6-bit codes, a 6-bit counter, window exponents clamped to 2..7 and a 4-bit settle length. A 128-sample window of all ones therefore overruns the counter, which makes saturation observable. Requests of 0 and 9 for the exponent reach both clamp limits. The short windows let whole grids complete in a few thousand cycles, so every write of every scan is compared against a behavioural slicer. That slicer has a known noise threshold, a phase-dependent waveform and an eye with a graded error border. The end-of-scan cycle count confirms the settle and window timing, and a second start pulse in the middle of a scan checks that it is ignored.

// File: rtl/escan_pkg.sv
// Shared encodings for the receiver margin scan controller.
package escan_pkg;
    typedef enum logic [1:0] {
        SCAN_NOISE = 2'd0,
        SCAN_WAVE  = 2'd1,
        SCAN_EYE   = 2'd2
    } scan_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_COUNT  = 3'd2,
        ST_WRITE  = 3'd3,
        ST_DONE   = 3'd4
    } scan_state_e;
endpackage

// File: rtl/escan_stepper.sv
// Grid stepper: holds the offset and phase codes and walks them
// offset-inner, phase-outer. In row mode only one phase row is scanned.
// Assumes off_first <= off_last and ph_first <= ph_last.
module escan_stepper #(
    parameter int OFF_W = 6,
    parameter int PH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic             row_only,
    input  logic [OFF_W-1:0] off_first,
    input  logic [OFF_W-1:0] off_last,
    input  logic [PH_W-1:0]  ph_first,
    input  logic [PH_W-1:0]  ph_last,
    output logic [OFF_W-1:0] off_code,
    output logic [PH_W-1:0]  ph_code,
    output logic             last_point,
    output logic             first_col
);
    logic [OFF_W-1:0] off_lo, off_hi;
    logic [PH_W-1:0]  ph_hi;
    logic             row_q;

    // Latch the range on load, then step the codes on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_lo   <= '0;
            off_hi   <= '0;
            ph_hi    <= '0;
            row_q    <= 1'b0;
            off_code <= '0;
            ph_code  <= '0;
        end else if (load) begin
            off_lo   <= off_first;
            off_hi   <= off_last;
            ph_hi    <= ph_last;
            row_q    <= row_only;
            off_code <= off_first;
            ph_code  <= ph_first;
        end else if (advance) begin
            if (off_code == off_hi) begin
                off_code <= off_lo;
                ph_code  <= ph_code + PH_W'(1);
            end else begin
                off_code <= off_code + OFF_W'(1);
            end
        end
    end

    // End-of-grid and start-of-row flags.
    always_comb begin
        last_point = (off_code == off_hi) && (row_q || (ph_code == ph_hi));
        first_col  = (off_code == off_lo);
    end

    // R3: after a step the offset stays inside the latched window.
    a_r3_offset_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (off_code >= off_lo && off_code <= off_hi));
endmodule

// File: rtl/escan_tally.sv
// Saturating event counter for one grid point. Cleared at the start of
// each point; increments when enabled and the hit input is high.
module escan_tally #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             hit,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // Count hits, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (en && hit && count != TOP)
            count <= count + CNT_W'(1);
    end

    // R7: a full counter stays full.
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit && !clear && count == TOP) |=> (count == TOP));
endmodule

// File: rtl/escan_diff.sv
// Density builder for noise scans: remembers the previous point's count
// and presents the signed drop to the current count on each write.
module escan_diff #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             allow,
    input  logic [CNT_W-1:0] cur,
    output logic             pdf_we,
    output logic [CNT_W:0]   pdf_val
);
    logic [CNT_W-1:0] prev;

    // Keep the count of the last written point.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev <= '0;
        else if (wr)
            prev <= cur;
    end

    // Difference output, valid together with the result write.
    always_comb begin
        pdf_we  = wr && allow;
        pdf_val = {1'b0, prev} - {1'b0, cur};
    end

    // R9: the magnitude of a difference never exceeds the count range.
    a_r9_diff_sign_fits: assert property (@(posedge clk) disable iff (!rst_n)
        pdf_we |-> (pdf_val[CNT_W] ? ({1'b0, cur} >= {1'b0, prev}) : ({1'b0, prev} >= {1'b0, cur})));
endmodule

// File: rtl/rx_margin_scan.sv
// Receiver margin scan controller. Sequences settle, count and write
// phases per grid point for noise, waveform and eye scans.
// Assumes one sample per clock on sample_bit/expect_bit and valid ranges.
module rx_margin_scan
    import escan_pkg::*;
#(
    parameter int OFF_W        = 6,
    parameter int PH_W         = 6,
    parameter int MIN_WIN_LOG2 = 8,
    parameter int MAX_WIN_LOG2 = 24,
    parameter int CNT_W        = MAX_WIN_LOG2 + 1,
    parameter int SETTLE_W     = 8,
    parameter int WINK_W       = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            scan_mode,
    input  logic [WINK_W-1:0]     win_log2,
    input  logic [SETTLE_W-1:0]   settle_len,
    input  logic [CNT_W-1:0]      err_limit,
    input  logic [OFF_W-1:0]      off_first,
    input  logic [OFF_W-1:0]      off_last,
    input  logic [PH_W-1:0]       ph_first,
    input  logic [PH_W-1:0]       ph_last,
    input  logic                  sample_bit,
    input  logic                  expect_bit,
    output logic [OFF_W-1:0]      off_code,
    output logic [PH_W-1:0]       ph_code,
    output logic                  res_we,
    output logic [OFF_W+PH_W-1:0] res_addr,
    output logic [CNT_W-1:0]      res_count,
    output logic                  res_pass,
    output logic                  pdf_we,
    output logic [CNT_W:0]        pdf_val,
    output logic                  busy,
    output logic                  done
);
    localparam int TMR_W = (MAX_WIN_LOG2 > SETTLE_W) ? MAX_WIN_LOG2 : SETTLE_W;

    scan_state_e         state;
    logic [1:0]          mode_q;
    logic [WINK_W-1:0]   k_q, k_eff;
    logic [SETTLE_W-1:0] settle_q;
    logic [CNT_W-1:0]    limit_q;
    logic [TMR_W-1:0]    timer, win_last, settle_last;
    logic                load, advance, last_point, first_col, row_mode;
    logic                eye_mode, hit;

    // Clamp the requested window exponent into the supported range.
    always_comb begin
        if (win_log2 < WINK_W'(MIN_WIN_LOG2))
            k_eff = WINK_W'(MIN_WIN_LOG2);
        else if (win_log2 > WINK_W'(MAX_WIN_LOG2))
            k_eff = WINK_W'(MAX_WIN_LOG2);
        else
            k_eff = win_log2;
    end

    // Derived per-point limits and control strobes.
    always_comb begin
        win_last    = (TMR_W'(1) << k_q) - TMR_W'(1);
        settle_last = TMR_W'(settle_q) - TMR_W'(1);
        load        = (state == ST_IDLE) && start;
        advance     = (state == ST_WRITE) && !last_point;
        row_mode    = (scan_mode == SCAN_NOISE);
        eye_mode    = mode_q[1];
        hit         = eye_mode ? (sample_bit ^ expect_bit) : sample_bit;
    end

    // Phase sequencer: settle, count, write per point, then done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            timer    <= '0;
            mode_q   <= '0;
            k_q      <= '0;
            settle_q <= '0;
            limit_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    mode_q   <= scan_mode;
                    k_q      <= k_eff;
                    settle_q <= settle_len;
                    limit_q  <= err_limit;
                    timer    <= '0;
                    state    <= (settle_len == '0) ? ST_COUNT : ST_SETTLE;
                end
                ST_SETTLE: if (timer == settle_last) begin
                    timer <= '0;
                    state <= ST_COUNT;
                end else begin
                    timer <= timer + TMR_W'(1);
                end
                ST_COUNT: if (timer == win_last) begin
                    timer <= '0;
                    state <= ST_WRITE;
                end else begin
                    timer <= timer + TMR_W'(1);
                end
                ST_WRITE: begin
                    if (last_point)
                        state <= ST_DONE;
                    else
                        state <= (settle_q == '0) ? ST_COUNT : ST_SETTLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    escan_stepper #(.OFF_W(OFF_W), .PH_W(PH_W)) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .advance    (advance),
        .row_only   (row_mode),
        .off_first  (off_first),
        .off_last   (off_last),
        .ph_first   (ph_first),
        .ph_last    (ph_last),
        .off_code   (off_code),
        .ph_code    (ph_code),
        .last_point (last_point),
        .first_col  (first_col)
    );

    escan_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load || advance),
        .en    (state == ST_COUNT),
        .hit   (hit),
        .count (res_count)
    );

    escan_diff #(.CNT_W(CNT_W)) u_diff (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (res_we),
        .allow   ((mode_q == SCAN_NOISE) && !first_col),
        .cur     (res_count),
        .pdf_we  (pdf_we),
        .pdf_val (pdf_val)
    );

    // Result port and handshake outputs.
    always_comb begin
        res_we   = (state == ST_WRITE);
        res_addr = {ph_code, off_code};
        res_pass = (res_count <= limit_q);
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
    end

    // R4: codes hold still while samples are being counted.
    a_r4_codes_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && $past(state) == ST_COUNT) |-> ($stable(off_code) && $stable(ph_code)));

    // R10: done lasts a single cycle and is followed by idle.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10: configuration cannot change once a scan is running.
    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(mode_q) && $stable(k_q) && $stable(limit_q)));

    // R9: density writes only accompany noise-mode result writes.
    a_r9_diff_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        pdf_we |-> (res_we && mode_q == SCAN_NOISE));
endmodule

// File: tb/rx_margin_scan_test.sv
module rx_margin_scan_test;
    localparam int OFF_W = 6, PH_W = 6, CNT_W = 6, SETTLE_W = 4, WINK_W = 5;
    localparam int CMAX = 63;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] scan_mode = '0;
    logic [WINK_W-1:0] win_log2 = '0;
    logic [SETTLE_W-1:0] settle_len = '0;
    logic [CNT_W-1:0] err_limit = '0;
    logic [OFF_W-1:0] off_first = '0, off_last = '0;
    logic [PH_W-1:0] ph_first = '0, ph_last = '0;
    logic sample_bit = 1'b0, expect_bit = 1'b0;
    logic [OFF_W-1:0] off_code;
    logic [PH_W-1:0] ph_code;
    logic res_we, res_pass, pdf_we, busy, done;
    logic [OFF_W+PH_W-1:0] res_addr;
    logic [CNT_W-1:0] res_count;
    logic [CNT_W:0] pdf_val;

    int n_chk = 0, n_bad = 0, cycles = 0;
    // scenario state owned by the bench
    int sc_kind = 0, sc_thr = 0, sc_win = 4, sc_lim = 0;
    int sc_olo = 0, sc_ohi = 0, sc_plo = 0, sc_phi = 0;
    int exp_off = 0, exp_ph = 0, n_wr = 0, n_pdf = 0, prev_exp = 0;
    logic [15:0] tick = '0;

    always #2.5 clk = ~clk;

    rx_margin_scan #(.OFF_W(OFF_W), .PH_W(PH_W), .MIN_WIN_LOG2(2), .MAX_WIN_LOG2(7),
        .CNT_W(CNT_W), .SETTLE_W(SETTLE_W), .WINK_W(WINK_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .scan_mode(scan_mode), .win_log2(win_log2),
        .settle_len(settle_len), .err_limit(err_limit), .off_first(off_first), .off_last(off_last),
        .ph_first(ph_first), .ph_last(ph_last), .sample_bit(sample_bit), .expect_bit(expect_bit),
        .off_code(off_code), .ph_code(ph_code), .res_we(res_we), .res_addr(res_addr),
        .res_count(res_count), .res_pass(res_pass), .pdf_we(pdf_we), .pdf_val(pdf_val),
        .busy(busy), .done(done));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dist1(input int v, input int lo, input int hi);
        return (v < lo) ? lo - v : (v > hi) ? v - hi : 0;
    endfunction

    // expected count at a grid point for the active scenario
    function automatic int model(input int off, input int ph);
        int raw, d;
        case (sc_kind)
            0: raw = (off < sc_thr) ? sc_win : (off == sc_thr) ? sc_win / 2 : 0;
            1: raw = (off < 4 + 3 * ph) ? sc_win : 0;
            default: begin
                d = dist1(off, 22, 25) + dist1(ph, 9, 10);
                raw = (d == 0) ? 0 : (d == 1) ? sc_win / 4 : sc_win;
            end
        endcase
        return (raw > CMAX) ? CMAX : raw;
    endfunction

    // behavioural slicer, updated away from the active edge
    always @(negedge clk) begin
        int off, ph, d;
        logic err;
        off = int'(off_code);
        ph = int'(ph_code);
        case (sc_kind)
            0: begin
                sample_bit <= (off < sc_thr) ? 1'b1 : (off == sc_thr) ? tick[0] : 1'b0;
                expect_bit <= 1'b0;
            end
            1: begin
                sample_bit <= (off < 4 + 3 * ph);
                expect_bit <= 1'b0;
            end
            default: begin
                d = dist1(off, 22, 25) + dist1(ph, 9, 10);
                err = (d == 0) ? 1'b0 : (d == 1) ? (tick[1:0] == 2'b00) : 1'b1;
                expect_bit <= tick[2];
                sample_bit <= tick[2] ^ err;
            end
        endcase
        tick <= tick + 16'd1;
    end

    // result monitor: order, count, pass flag and density
    always @(negedge clk) begin
        int e;
        if (rst_n && res_we) begin
            e = model(exp_off, exp_ph);
            chk(res_addr == {PH_W'(exp_ph), OFF_W'(exp_off)}, "R2/R3 address", int'(res_addr), exp_ph * 64 + exp_off);
            chk(int'(res_count) == e, (sc_kind == 2) ? "R6 error count" : "R5 ones count", int'(res_count), e);
            chk(res_pass == (e <= sc_lim), "R6 pass flag", int'(res_pass), int'(e <= sc_lim));
            if (sc_kind == 0 && exp_off != sc_olo) begin
                chk(pdf_we, "R9 density strobe", int'(pdf_we), 1);
                chk(int'($signed(pdf_val)) == prev_exp - e, "R9 density value", int'($signed(pdf_val)), prev_exp - e);
            end else begin
                chk(!pdf_we, "R9 no density", int'(pdf_we), 0);
            end
            prev_exp = e;
            n_wr++;
            if (exp_off == sc_ohi) begin exp_off = sc_olo; exp_ph++; end
            else exp_off++;
        end
        if (rst_n && pdf_we) n_pdf++;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // start a scan; returns cycles from start edge to done
    task automatic run(input int kind, input int md, input int k, input int s, input int lim,
                       input int olo, input int ohi, input int plo, input int phi,
                       input int kwin, input int tamper_at, output int took);
        sc_kind = kind; sc_win = 1 << kwin; sc_lim = lim;
        sc_olo = olo; sc_ohi = ohi; sc_plo = plo; sc_phi = phi;
        exp_off = olo; exp_ph = plo; n_wr = 0; n_pdf = 0; prev_exp = 0;
        scan_mode = 2'(md); win_log2 = WINK_W'(k); settle_len = SETTLE_W'(s);
        err_limit = CNT_W'(lim); off_first = OFF_W'(olo); off_last = OFF_W'(ohi);
        ph_first = PH_W'(plo); ph_last = PH_W'(phi);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        took = 0;
        while (!done) begin
            took++;
            if (took == tamper_at) begin
                scan_mode = 2'd0; win_log2 = 5'd2; off_first = 6'd0; off_last = 6'd1;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R10 idle after done", int'(busy), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done, "R1 reset idle", int'(busy) + int'(done), 0);
        chk(!res_we && !pdf_we, "R1 reset no write", int'(res_we) + int'(pdf_we), 0);
        chk(off_code == 0 && ph_code == 0, "R1 reset codes", int'(off_code) + int'(ph_code), 0);
    endtask

    task automatic t_noise();
        int took;
        sc_thr = 15;
        run(0, 0, 4, 3, 0, 10, 20, 7, 7, 4, -1, took);
        chk(n_wr == 11, "R2 noise row writes", n_wr, 11);
        chk(n_pdf == 10, "R9 density writes", n_pdf, 10);
        chk(took == 11 * (3 + 16 + 1), "R4 noise timing", took, 220);
    endtask

    task automatic t_wave();
        int took;
        run(1, 1, 4, 1, 8, 0, 15, 0, 3, 4, 100, took);
        chk(n_wr == 64, "R3 grid writes, R10 start ignored", n_wr, 64);
        chk(n_pdf == 0, "R9 no density in waveform", n_pdf, 0);
        chk(took == 64 * (1 + 16 + 1), "R4 waveform timing", took, 64 * 18);
    endtask

    task automatic t_eye();
        int took;
        run(2, 2, 5, 2, 8, 20, 27, 8, 11, 5, -1, took);
        chk(n_wr == 32, "R3 eye writes", n_wr, 32);
        chk(took == 32 * (2 + 32 + 1), "R4 eye timing", took, 32 * 35);
    endtask

    task automatic t_saturate();
        int took;
        sc_thr = 40;
        run(0, 0, 9, 1, 10, 0, 1, 0, 0, 7, -1, took);
        chk(n_wr == 2, "R7 writes", n_wr, 2);
        chk(took == 2 * (1 + 128 + 1), "R8 upper clamp timing", took, 260);
    endtask

    task automatic t_low_clamp();
        int took;
        sc_thr = 40;
        run(0, 0, 0, 0, 1, 39, 41, 5, 5, 2, -1, took);
        chk(n_wr == 3, "R8 lower clamp writes", n_wr, 3);
        chk(took == 3 * (0 + 4 + 1), "R8 lower clamp timing", took, 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_noise();
        t_wave();
        t_eye();
        t_saturate();
        t_low_clamp();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule